// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of one read or write burst on a double-data-rate memory device. The command path gives it a starting column, a length code and an ordering mode, and pulses a start strobe. On each following cycle the block presents one column address with a valid flag. It also raises a last-beat flag on the final address of the burst.

Only the low column bits that index inside the aligned block move during a burst. The block is one, two or three bits wide for lengths 2, 4 and 8. The column bits above that block stay at the starting value. Two orderings are selectable for each burst. Sequential ordering counts up from the starting offset and wraps back inside the block. Interleaved ordering uses the starting offset XOR the beat number. A new start strobe at any time aborts the burst in progress and begins the new one on the next cycle.

Top module: `burstColSeq`

## Requirements
- R1: The `lenSel` encoding is: 0 selects 2 beats, 1 selects 4 beats, and 2 or 3 select 8 beats. `beatValid` stays high for exactly that many consecutive cycles after a start.
- R2: In the cycle after `startStb` is sampled high, `beatValid` is 1 and `beatCol` equals the sampled `startCol`.
- R3: With `interleave`=0 (sequential), the in-block offset of beat i is (s + i) mod L. Here s is the starting offset and L is the length (for example, start 5 at length 8 gives 5,6,7,0,1,2,3,4).
- R4: With `interleave`=1 (interleaved), the in-block offset of beat i is s XOR i (for example, start 5 at length 8 gives 5,4,7,6,1,0,3,2).
- R5: The column bits above the low log2(L) bits equal those of the starting column on every beat of the burst.
- R6: `beatLast` is high exactly on the final beat of a burst, and it is never high while `beatValid` is low.
- R7: In the cycle after the last beat, `beatValid` is 0 unless `startStb` was high in the last-beat cycle. In that case the new burst follows without a gap.
- R8: A `startStb` during a burst aborts that burst. The next cycle shows the first beat of the new burst.
- R9: Changes on `startCol`, `lenSel` and `interleave` while `startStb` is low have no effect on the burst in progress.
- R10: A synchronous active-high `rst` makes `beatValid` and `beatLast` low in the following cycle, including in the middle of a burst.
- R11: At length 4 with starting offset 2, both orderings give 2,3,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| startStb | input | 1 | Starts a burst with the current inputs |
| startCol | input | COL_W | Starting column address |
| lenSel | input | 2 | Burst length code |
| interleave | input | 1 | 0 sequential, 1 interleaved ordering |
| beatValid | output | 1 | A column address is presented this cycle |
| beatLast | output | 1 | This is the final beat of the burst |
| beatCol | output | COL_W | Column address of the current beat |

## Verification
The assertions assume that `startStb` is a known value after reset and that `startCol` is stable in any cycle where `startStb` is sampled. This lets the first-beat check compare against the previous cycle's inputs. The bench drives every input on the falling edge. It holds each strobe for exactly one cycle. It then scrambles the start inputs while bursts run, which checks that only latched values shape the sequence. Aborts and back-to-back starts are issued only at falling edges, so each restart lands on a single known rising edge.

// File: rtl/burstColSeqPkg.sv
package burstColSeqPkg;
  localparam int OFF_W = 3;
  localparam int LEN_W = 2;

  typedef enum logic {ORDER_SEQ = 1'b0, ORDER_ILV = 1'b1} burstOrder_t;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic [OFF_W-1:0] nextBeat;
  } seqStrobe_t;

  // In-block offset mask; equals the index of the final beat.
  function automatic logic [OFF_W-1:0] lenMask(input logic [LEN_W-1:0] code);
    case (code)
      2'd0:    lenMask = 3'b001;
      2'd1:    lenMask = 3'b011;
      default: lenMask = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/burstColCtrl.sv
module burstColCtrl
  import burstColSeqPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             startStb,
  input  logic [LEN_W-1:0] lenSel,
  output seqStrobe_t       strobe,
  output logic             beatValid,
  output logic             beatLast
);
  logic             active;
  logic [OFF_W-1:0] beatCnt;
  logic [OFF_W-1:0] lastIdx;
  logic             lastHit;

  assign lastHit = active && (beatCnt == lastIdx);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      beatCnt <= '0;
      lastIdx <= '0;
    end else if (startStb) begin
      active  <= 1'b1;
      beatCnt <= '0;
      lastIdx <= lenMask(lenSel);
    end else if (lastHit) begin
      active  <= 1'b0;
      beatCnt <= '0;
    end else if (active) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.load     = startStb;
    strobe.advance  = active && !lastHit && !startStb;
    strobe.nextBeat = beatCnt + 1'b1;
  end

  assign beatValid = active;
  assign beatLast  = lastHit;
endmodule

// File: rtl/burstColDatapath.sv
module burstColDatapath
  import burstColSeqPkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             interleave,
  output logic [COL_W-1:0] beatCol
);
  localparam int HI_W = COL_W - OFF_W;

  logic [COL_W-1:0] addrReg;
  logic [OFF_W-1:0] startOff;
  logic [OFF_W-1:0] maskReg;
  burstOrder_t      orderReg;
  logic [OFF_W-1:0] seqOff;
  logic [OFF_W-1:0] ilvOff;
  logic [OFF_W-1:0] pickOff;
  logic [OFF_W-1:0] lowNext;

  always_comb begin
    seqOff  = startOff + strobe.nextBeat;
    ilvOff  = startOff ^ strobe.nextBeat;
    pickOff = (orderReg == ORDER_ILV) ? ilvOff : seqOff;
  end

  // Per-bit select: bits inside the block follow the order, bits above hold.
  for (genvar b = 0; b < OFF_W; b++) begin : gLow
    assign lowNext[b] = maskReg[b] ? pickOff[b] : addrReg[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= '0;
      startOff <= '0;
      maskReg  <= '0;
      orderReg <= ORDER_SEQ;
    end else if (strobe.load) begin
      addrReg  <= startCol;
      startOff <= startCol[OFF_W-1:0];
      maskReg  <= lenMask(lenSel);
      orderReg <= burstOrder_t'(interleave);
    end else if (strobe.advance) begin
      addrReg  <= {addrReg[COL_W-1:OFF_W], lowNext};
    end
  end

  assign beatCol = addrReg;

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = addrReg[COL_W-1:OFF_W];
endmodule

// File: rtl/burstColSeq.sv
module burstColSeq
  import burstColSeqPkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenSel,
  input  logic             interleave,
  output logic             beatValid,
  output logic             beatLast,
  output logic [COL_W-1:0] beatCol
);
  seqStrobe_t strobe;

  burstColCtrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .startStb  (startStb),
    .lenSel    (lenSel),
    .strobe    (strobe),
    .beatValid (beatValid),
    .beatLast  (beatLast)
  );

  burstColDatapath #(.COL_W(COL_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .startCol   (startCol),
    .lenSel     (lenSel),
    .interleave (interleave),
    .beatCol    (beatCol)
  );
endmodule

// File: rtl/burstColSeqChk.sv
module burstColSeqChk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic             beatValid,
  input logic             beatLast,
  input logic [COL_W-1:0] beatCol
);
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    startStb |=> (beatValid && beatCol == $past(startCol))); // R2

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (beatValid && !beatLast && !startStb) |=> (beatCol[COL_W-1:3] == $past(beatCol[COL_W-1:3]))); // R5

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    beatLast |-> beatValid); // R6

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (beatLast && !startStb) |=> !beatValid); // R7

  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    (beatValid && !beatLast) |=> beatValid); // R1

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!beatValid && !beatLast)); // R10
endmodule

bind burstColSeq burstColSeqChk #(.COL_W(COL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .startStb  (startStb),
  .startCol  (startCol),
  .beatValid (beatValid),
  .beatLast  (beatLast),
  .beatCol   (beatCol)
);

// File: tb/burstColSeq_tb_top.sv
module burstColSeq_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [1:0]       lenSel = 2'd0;
  logic             interleave = 1'b0;
  logic             beatValid;
  logic             beatLast;
  logic [COL_W-1:0] beatCol;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  burstColSeq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .startStb(startStb), .startCol(startCol),
    .lenSel(lenSel), .interleave(interleave),
    .beatValid(beatValid), .beatLast(beatLast), .beatCol(beatCol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lenOf(input logic [1:0] code);
    return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
  endfunction

  function automatic int expCol(input int col, input logic [1:0] code, input bit ilv, input int i);
    int l = lenOf(code);
    int s = col % l;
    int off = ilv ? (s ^ i) : ((s + i) % l);
    return (col - s) + off;
  endfunction

  // Called at a falling edge; first beat is visible at the next falling edge.
  task automatic launch(input int col, input logic [1:0] code, input bit ilv);
    startStb   = 1'b1;
    startCol   = col[COL_W-1:0];
    lenSel     = code;
    interleave = ilv;
    @(negedge clk);
    startStb   = 1'b0;
    startCol   = ~startCol;   // R9: scrambled inputs must not matter
    lenSel     = ~code;
    interleave = ~ilv;
  endtask

  // Checks beats 0..n-1; returns at the falling edge showing beat n-1.
  task automatic expectBeats(input int col, input logic [1:0] code, input bit ilv,
                             input int n, input string req);
    int l = lenOf(code);
    for (int i = 0; i < n; i++) begin
      check(beatValid === 1'b1, {req, " valid"}, int'(beatValid), 1);
      check(int'(beatCol) == expCol(col, code, ilv, i), req, int'(beatCol),
            expCol(col, code, ilv, i));
      check(beatLast === (i == l - 1), "R6 last flag", int'(beatLast), int'(i == l - 1));
      if (i < n - 1) @(negedge clk);
    end
  endtask

  task automatic fullBurst(input int col, input logic [1:0] code, input bit ilv, input string req);
    launch(col, code, ilv);
    expectBeats(col, code, ilv, lenOf(code), req);
    @(negedge clk);
    check(beatValid === 1'b0, "R1 R7 idle after last", int'(beatValid), 0);
  endtask

  task automatic tReset();
    @(negedge clk); @(negedge clk);
    check(beatValid === 1'b0 && beatLast === 1'b0, "R10 reset idle", int'(beatValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(beatValid === 1'b0, "R10 idle after reset", int'(beatValid), 0);
  endtask

  task automatic tSequential();
    fullBurst(10'h2D5 & ~10'h7 | 5, 2'd2, 1'b0, "R3 seq len8 start5");
    fullBurst(10'h13B, 2'd1, 1'b0, "R3 R5 seq len4 start3");
    fullBurst(10'h0A1, 2'd0, 1'b0, "R3 R1 seq len2 start1");
    fullBurst(10'h3F0, 2'd3, 1'b0, "R1 code3 len8");
  endtask

  task automatic tInterleaved();
    fullBurst(10'h1C5, 2'd2, 1'b1, "R4 ilv len8 start5");
    fullBurst(10'h0F7, 2'd2, 1'b1, "R4 R5 ilv len8 start7");
    fullBurst(10'h2A3, 2'd1, 1'b1, "R4 ilv len4 start3");
    fullBurst(10'h300, 2'd0, 1'b1, "R4 ilv len2 start0");
  endtask

  task automatic tBoundary();
    fullBurst(10'h16A, 2'd1, 1'b0, "R11 seq len4 start2");
    fullBurst(10'h16A, 2'd1, 1'b1, "R11 ilv len4 start2");
  endtask

  task automatic tAbort();
    launch(10'h0C6, 2'd2, 1'b0);
    expectBeats(10'h0C6, 2'd2, 1'b0, 3, "R8 first burst");
    launch(10'h251, 2'd1, 1'b1);
    expectBeats(10'h251, 2'd1, 1'b1, 4, "R8 aborting burst");
    @(negedge clk);
    check(beatValid === 1'b0, "R8 idle after restart", int'(beatValid), 0);
  endtask

  task automatic tBackToBack();
    launch(10'h11F, 2'd0, 1'b0);
    expectBeats(10'h11F, 2'd0, 1'b0, 2, "R7 first of pair");
    launch(10'h23C, 2'd2, 1'b1);
    expectBeats(10'h23C, 2'd2, 1'b1, 8, "R7 gapless second");
    @(negedge clk);
    check(beatValid === 1'b0, "R7 idle after pair", int'(beatValid), 0);
  endtask

  task automatic tMidReset();
    launch(10'h345, 2'd2, 1'b0);
    expectBeats(10'h345, 2'd2, 1'b0, 2, "R10 before reset");
    rst = 1'b1;
    @(negedge clk);
    check(beatValid === 1'b0 && beatLast === 1'b0, "R10 mid-burst reset", int'(beatValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(beatValid === 1'b0, "R10 stays idle", int'(beatValid), 0);
  endtask

  initial begin
    tReset();
    tSequential();
    tInterleaved();
    tBoundary();
    tAbort();
    tBackToBack();
    tMidReset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule